// File: doc/BRIEF.md
# Byte-Lane Gated Register Write Port

This block sits between a simple register bus and a bank of 32-bit registers that cannot take byte strobes from the bus itself. Instead, a separate lane-control register holds a four-bit lane mask. Software first programs that mask and then issues an ordinary full-word data write. Only the byte lanes whose mask bit is set are updated in the addressed word. Every other lane keeps its old contents.

Software derives the mask from the width and position of the access it wants:
- A full-word access enables every lane. Software writes 0xF8 to the control register, and only bits 6:3 of that value are kept.
- A 16-bit access enables two adjacent lanes, binary 11, shifted left by the low two address bits.
- An 8-bit access enables one lane, shifted left by the low two address bits.

The data byte or halfword is placed on its natural lanes of the bus word. The mask stays in force until it is rewritten. Each control write therefore qualifies every data write that follows it. Software must keep a control/data pair together, with no other writer in between.

A small register file is the target of the gated writes. A one-cycle registered read port returns either a register word or the control register.

Top module: `lane_write_gate`

## Requirements
- R1: After a synchronous reset the lane mask has all four lanes enabled, so a control read returns 0x00000078, and rd_valid is low.
- R2: A write with wr_space = 1 (control space) stores wr_data[6:3] as the lane mask, with bit 3+l enabling lane l. A control read returns the mask in bits 6:3, and every other bit reads as zero.
- R3: A write with wr_space = 0 (data space) to byte address A updates word A[5:2]. For each lane l whose mask bit is set, byte lane l of the word takes wr_data[8l+7:8l].
- R4: Lanes whose mask bit is clear keep their previous contents. A data write with an all-zero mask leaves the word unchanged.
- R5: The mask is not cleared by use. It stays unchanged across any number of data writes until the next control write.
- R6: A control write takes effect for the data write in the very next cycle.
- R7: A read issued in cycle N presents rd_data with rd_valid high after the next clock edge. If a read and a write address the same location in one cycle, the read returns the contents from before the write.
- R8: Control-space writes do not alter the register file, and data-space writes do not alter the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_space | input | 1 | Write target: 0 register file, 1 lane-control register |
| wr_addr | input | 6 | Byte address of the write; bits 5:2 select the word |
| wr_data | input | 32 | Write data, byte lane l in bits 8l+7:8l |
| rd_en | input | 1 | Read strobe |
| rd_space | input | 1 | Read target: 0 register file, 1 lane-control register |
| rd_addr | input | 6 | Byte address of the read; bits 5:2 select the word |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Registered read data |

## Verification
The bench goes after three kinds of error.

The first is the mask lifetime. A data write follows a control write back to back, and a long run of data writes follows a single mask. A design that latched the mask one cycle late, or cleared it after use, would then corrupt or drop lanes.

The second is partial masks: 8-bit writes at every lane offset, 16-bit writes at both halves, and an all-zero mask. A design that leaked writes into disabled lanes would overwrite neighbouring bytes that the model still holds.

The third is the control register itself and same-cycle read/write collisions. Writing all-ones to the control register exposes any stray bits kept or read back outside bits 6:3. A write-first memory would show the new value where the old one is expected.

// File: rtl/lane_gate_pkg.sv
package lane_gate_pkg;
  // Target space selected by wr_space / rd_space
  typedef enum logic {
    SPACE_DATA = 1'b0,
    SPACE_CTRL = 1'b1
  } space_e;

  // Bit position of lane 0's enable inside the control register
  localparam int CTRL_MASK_LSB = 3;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl #(
  parameter int LANES    = 4,
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic [LANES-1:0]  lane_mask
);
  logic [LANES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (ctrl_we) begin
      mask_q <= ctrl_wdata[MASK_LSB +: LANES];
    end
  end

  assign lane_mask = mask_q;

  // R1: reset leaves every lane enabled
  assert_reset_mask_R1: assert property (@(posedge clk)
    rst |=> mask_q == {LANES{1'b1}});

  // R5: mask unchanged whenever no control write occurs
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(mask_q));

  // R6: a control write is in force on the following cycle
  assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> mask_q == $past(ctrl_wdata[MASK_LSB +: LANES]));
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int DEPTH  = 16,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rdata_q;

  // Read-first single-clock RAM, one byte lane wide
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lane_readback.sv
module lane_readback #(
  parameter int LANES    = 4,
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_ctrl,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              valid_q;
  logic              ctrl_sel_q;
  logic [DATA_W-1:0] ctrl_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      ctrl_sel_q  <= 1'b0;
      ctrl_word_q <= '0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) begin
        ctrl_sel_q  <= rd_ctrl;
        ctrl_word_q <= DATA_W'(lane_mask) << MASK_LSB;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = ctrl_sel_q ? ctrl_word_q : bank_rdata;

  // R7: every read strobe produces a valid beat one cycle later
  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R2: control readback shows nothing outside the mask field
  assert_ctrl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ctrl_sel_q) |->
      ((rd_data & ~(DATA_W'({LANES{1'b1}}) << MASK_LSB)) == '0));
endmodule

// File: rtl/lane_write_gate.sv
module lane_write_gate
  import lane_gate_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(LANES),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_space,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_space,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              ctrl_we;
  logic              data_we;
  logic              data_re;
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] bank_rdata;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  assign ctrl_we = wr_en && (wr_space == SPACE_CTRL);
  assign data_we = wr_en && (wr_space == SPACE_DATA);
  assign data_re = rd_en && (rd_space == SPACE_DATA);
  assign wr_idx  = wr_addr[ADDR_W-1:OFF_W];
  assign rd_idx  = rd_addr[ADDR_W-1:OFF_W];

  lane_ctrl #(
    .LANES    (LANES),
    .DATA_W   (DATA_W),
    .MASK_LSB (CTRL_MASK_LSB)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (wr_data),
    .lane_mask  (lane_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_bank #(
      .DEPTH  (DEPTH),
      .LANE_W (LANE_W)
    ) u_bank (
      .clk   (clk),
      .we    (data_we && lane_mask[l]),
      .waddr (wr_idx),
      .wdata (wr_data[l*LANE_W +: LANE_W]),
      .re    (data_re),
      .raddr (rd_idx),
      .rdata (bank_rdata[l*LANE_W +: LANE_W])
    );
  end

  lane_readback #(
    .LANES    (LANES),
    .DATA_W   (DATA_W),
    .MASK_LSB (CTRL_MASK_LSB)
  ) u_rb (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_ctrl    (rd_space == SPACE_CTRL),
    .lane_mask  (lane_mask),
    .bank_rdata (bank_rdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/tb_lane_write_gate.sv
`timescale 1ns/1ps
module tb_lane_write_gate;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_space = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0, rd_space = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] model_mem [DEPTH];
  logic [3:0]  model_mask;

  always #10 clk = ~clk;

  lane_write_gate dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_space(wr_space),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_space(rd_space), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  function automatic logic [31:0] merge(input logic [31:0] old,
                                        input logic [31:0] d,
                                        input logic [3:0] m);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = d[l*8 +: 8];
    return r;
  endfunction

  // size: 0 byte, 1 halfword, 2 word
  function automatic logic [31:0] ctrl_for(input int size, input logic [1:0] off);
    if (size == 2) return 32'h0000_00F8;
    if (size == 1) return 32'((4'b0011 << off) << 3);
    return 32'((4'b0001 << off) << 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_ctrl(input logic [31:0] v);
    wr_en = 1; wr_space = 1; wr_data = v; wr_addr = '0;
    @(negedge clk);
    wr_en = 0;
    model_mask = v[6:3];
  endtask

  task automatic do_data(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1; wr_space = 0; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_mem[a[5:2]] = merge(model_mem[a[5:2]], d, model_mask);
  endtask

  task automatic rd_word(input string req, input logic [3:0] w);
    rd_en = 1; rd_space = 0; rd_addr = {w, 2'b00};
    @(negedge clk);
    rd_en = 0;
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, model_mem[w]);
  endtask

  task automatic rd_ctrl(input string req);
    rd_en = 1; rd_space = 1; rd_addr = '0;
    @(negedge clk);
    rd_en = 0;
    check(req, rd_data, {25'd0, model_mask, 3'd0});
  endtask

  task automatic sized_write(input int size, input logic [5:0] a,
                             input logic [31:0] v);
    do_ctrl(ctrl_for(size, a[1:0]));
    do_data(a, v << (8 * a[1:0]));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'd20240611));
    model_mask = 4'hF;
    for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_valid low", {31'd0, rd_valid}, 32'd0);
    rst = 0;
    @(negedge clk);
    rd_ctrl("R1 reset mask");

    // Fill every word with full-lane writes (R3)
    for (int i = 0; i < DEPTH; i++) do_data(6'(i * 4), $urandom);
    for (int i = 0; i < DEPTH; i++) rd_word("R3 full write", 4'(i));

    // R2: stray bits ignored
    do_ctrl(32'hFFFF_FF87);
    rd_ctrl("R2 stray bits");
    do_ctrl(32'hFFFF_FFFF);
    rd_ctrl("R2 all ones");

    // R4: zero mask leaves the word intact
    do_ctrl(32'h0);
    do_data(6'd8, 32'hDEAD_BEEF);
    rd_word("R4 zero mask", 4'd2);

    // R6: back-to-back, byte lanes at every offset
    for (int o = 0; o < 4; o++) begin
      sized_write(0, 6'(20 + o), 32'(8'hA0 + o));
      rd_word("R6 byte lane", 4'd5);
    end
    sized_write(1, 6'd24, 32'h1234);
    sized_write(1, 6'd26, 32'h5678);
    rd_word("R4 halfwords", 4'd6);

    // R5: mask persists over many writes; R8: data writes keep mask
    do_ctrl(ctrl_for(0, 2'd1));
    for (int i = 0; i < DEPTH; i++) do_data(6'(i * 4), $urandom);
    rd_ctrl("R8 mask after data writes");
    for (int i = 0; i < DEPTH; i++) rd_word("R5 persistent mask", 4'(i));

    // R8: control writes leave memory untouched
    do_ctrl(32'h0000_0050);
    do_ctrl(32'h0000_0028);
    rd_word("R8 memory after ctrl", 4'd7);

    // R7: same-cycle read/write returns old contents
    do_ctrl(32'h0000_00F8);
    old = model_mem[3];
    wr_en = 1; wr_space = 0; wr_addr = 6'd12; wr_data = 32'hCAFE_F00D;
    rd_en = 1; rd_space = 0; rd_addr = 6'd12;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R7 read-first", rd_data, old);
    model_mem[3] = 32'hCAFE_F00D;
    rd_word("R7 after collision", 4'd3);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 8);
      logic [5:0] a = 6'($urandom);
      case (op)
        0: do_ctrl($urandom);
        1, 2: do_data(a, $urandom);
        3: sized_write(2, {a[5:2], 2'b00}, $urandom);
        4: sized_write(1, {a[5:2], a[1], 1'b0}, $urandom);
        5: sized_write(0, a, $urandom);
        6: rd_word("R3 random", a[5:2]);
        default: rd_ctrl("R2 random");
      endcase
    end
    for (int i = 0; i < DEPTH; i++) rd_word("R4 final sweep", 4'(i));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule